// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block gives software control over a bank of up to 32 general-purpose pins through a simple word-wide register bus. Each pin can be handed to an alternate-function source, or left under register control with its own direction, drive-enable and drive value. Each pin's level can be read back after a two-flop synchroniser.

Every pin also feeds an event detector. The detector can look for an active-high or active-low level, a rising edge, a falling edge, or either edge. Detected events collect in a status word. That word is cleared by the act of reading it, and no acknowledge register exists. A per-pin mask is changed only through a write-one-to-unmask register and a write-one-to-mask register. The masked status bits are ORed into one interrupt line.

Top module: `gpio_hub`

## Requirements
- R1: After reset, every implemented direction bit is 1 (input), every mask bit is 1 (masked), and the alternate-select, drive-enable and drive-value words are 0. As a result the pad drive enable is 0 and the interrupt line is low.
- R2: The registers sit at byte offsets 0x00 alternate select, 0x04 direction, 0x08 drive enable, 0x0C drive value, 0x10 pin level (read-only), 0x14 mask (read-only), 0x18 unmask, 0x1C mask-set, 0x20 status, 0x24 detect kind, 0x28 polarity and 0x2C both-edge. Bit n of each register belongs to pin n. Writable configuration words read back what was written.
- R3: For a pin whose alternate-select bit is 0, a direction bit of 1 forces pad drive enable to 0 whatever the drive-enable bit holds. A direction bit of 0 gives pad drive enable equal to the drive-enable bit. The pad output follows the drive-value bit.
- R4: For a pin whose alternate-select bit is 1, pad output and pad drive enable come from the alternate-function inputs.
- R5: The pin-level register returns the pad inputs after a two-flop synchroniser. A read captured on the second rising edge after an input change still returns the old value. A read captured on the third edge returns the new value.
- R6: Writing 1s to 0x18 clears those mask bits, and writing 1s to 0x1C sets them. Bits written as 0 change nothing. A write to 0x14 has no effect.
- R7: Detect-kind bit 1 selects level detection. Polarity bit 1 then means active high, and 0 means active low.
- R8: Detect-kind bit 0 selects edge detection. Both-edge bit 1 triggers on either edge. Otherwise polarity bit 1 means rising and 0 means falling.
- R9: A status bit is set by a detected event even while its pin is masked. The interrupt line is high exactly when some status bit is set whose mask bit is 0.
- R10: A read of 0x20 returns the status word and clears it. A level condition that is still present sets its bit again one cycle after the clearing read.
- R11: Unimplemented bits (at or above the pin count) read as 0. Unmapped or unaligned offsets read as 0.
- R12: Read data is registered. It changes on the rising edge that samples the read enable and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | 32 | Registered read data |
| padIn | input | PIN_COUNT | Asynchronous pad inputs |
| padOut | output | PIN_COUNT | Pad output value |
| padOe | output | PIN_COUNT | Pad drive enable |
| altOut | input | PIN_COUNT | Alternate-function output value |
| altOe | input | PIN_COUNT | Alternate-function drive enable |
| irqOut | output | 1 | Combined interrupt line |

## Verification
On every cycle, the checker enforces the set/clear effect of the unmask and mask-set writes on the mask word. It also checks that a fully masked bank keeps the interrupt line low, that an input pin under register control is never driven, and that a status read returns the word held before the read. The checker also confirms that unmapped reads return zero. The directed scenarios are the only way to show the synchroniser latency, the chosen level polarity, the rising/falling/either-edge selection, and the level condition setting its bit again one cycle after a clearing read. They also cover the alternate-function hand-over and the zero fill above the pin count.

// File: rtl/gpio_hub_pkg.sv
package gpio_hub_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned REG_CNT = 12;

  // Word index of each register; the index is the byte offset divided by 4.
  typedef enum logic [3:0] {
    SEL_ALT    = 4'd0,
    SEL_DIR    = 4'd1,
    SEL_DRVEN  = 4'd2,
    SEL_DRVVAL = 4'd3,
    SEL_PINS   = 4'd4,
    SEL_MASK   = 4'd5,
    SEL_IEN    = 4'd6,
    SEL_IDIS   = 4'd7,
    SEL_STAT   = 4'd8,
    SEL_KIND   = 4'd9,
    SEL_POL    = 4'd10,
    SEL_BOTH   = 4'd11,
    SEL_NONE   = 4'd15
  } regSel_e;

  typedef struct packed {
    logic    wrAlt;
    logic    wrDir;
    logic    wrDrvEn;
    logic    wrDrvVal;
    logic    wrIrqEn;
    logic    wrIrqDis;
    logic    wrKind;
    logic    wrPol;
    logic    wrBoth;
    logic    rdStb;
    logic    clrStat;
    regSel_e rdSel;
  } hubStrobe_t;

endpackage

// File: rtl/gpio_hub_ctrl.sv
module gpio_hub_ctrl
  import gpio_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output hubStrobe_t        stb
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             mapped;
  regSel_e          sel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign mapped  = aligned && (wordIdx < IDX_W'(REG_CNT));
  assign sel     = mapped ? regSel_e'(wordIdx[3:0]) : SEL_NONE;

  always_comb begin
    stb          = '0;
    stb.rdSel    = sel;
    stb.rdStb    = busRe;
    stb.clrStat  = busRe && (sel == SEL_STAT);
    if (busWe) begin
      unique case (sel)
        SEL_ALT:    stb.wrAlt    = 1'b1;
        SEL_DIR:    stb.wrDir    = 1'b1;
        SEL_DRVEN:  stb.wrDrvEn  = 1'b1;
        SEL_DRVVAL: stb.wrDrvVal = 1'b1;
        SEL_IEN:    stb.wrIrqEn  = 1'b1;
        SEL_IDIS:   stb.wrIrqDis = 1'b1;
        SEL_KIND:   stb.wrKind   = 1'b1;
        SEL_POL:    stb.wrPol    = 1'b1;
        SEL_BOTH:   stb.wrBoth   = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_hub_dp.sv
module gpio_hub_dp
  import gpio_hub_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hubStrobe_t           stb,
  input  logic [PIN_COUNT-1:0] wrBits,
  output logic [WORD_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic                 irqOut,
  output logic [PIN_COUNT-1:0] statusQ,
  output logic [PIN_COUNT-1:0] maskQ,
  output logic [PIN_COUNT-1:0] dirQ,
  output logic [PIN_COUNT-1:0] altSelQ
);

  localparam logic [PIN_COUNT-1:0] ALL_ONES = {PIN_COUNT{1'b1}};

  logic [PIN_COUNT-1:0] drvEnQ, drvValQ, kindQ, polQ, bothQ;
  logic [PIN_COUNT-1:0] syncA, syncQ, prevQ;
  logic [PIN_COUNT-1:0] lvlEv, edgeEv;
  logic [WORD_W-1:0]    rdWord;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altSelQ <= '0;
      dirQ    <= ALL_ONES;
      drvEnQ  <= '0;
      drvValQ <= '0;
      kindQ   <= '0;
      polQ    <= '0;
      bothQ   <= '0;
    end else begin
      if (stb.wrAlt)    altSelQ <= wrBits;
      if (stb.wrDir)    dirQ    <= wrBits;
      if (stb.wrDrvEn)  drvEnQ  <= wrBits;
      if (stb.wrDrvVal) drvValQ <= wrBits;
      if (stb.wrKind)   kindQ   <= wrBits;
      if (stb.wrPol)    polQ    <= wrBits;
      if (stb.wrBoth)   bothQ   <= wrBits;
    end
  end

  // mask: changed only by write-one set/clear strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= ALL_ONES;
    end else if (stb.wrIrqEn) begin
      maskQ <= maskQ & ~wrBits;
    end else if (stb.wrIrqDis) begin
      maskQ <= maskQ | wrBits;
    end
  end

  // two-flop synchroniser plus a history flop for edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncA <= padIn;
      syncQ <= syncA;
      prevQ <= syncQ;
    end
  end

  // per-pin event detection
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic riseP, fallP;
    assign riseP     = syncQ[p] & ~prevQ[p];
    assign fallP     = ~syncQ[p] & prevQ[p];
    assign lvlEv[p]  = kindQ[p] & (syncQ[p] == polQ[p]);
    assign edgeEv[p] = ~kindQ[p] &
                       (bothQ[p] ? (riseP | fallP) : (polQ[p] ? riseP : fallP));
  end

  // status: read clears; edges in the clearing cycle are kept,
  // levels come back on the next cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (stb.clrStat) begin
      statusQ <= edgeEv;
    end else begin
      statusQ <= statusQ | lvlEv | edgeEv;
    end
  end

  assign irqOut = |(statusQ & ~maskQ);

  // pad steering
  assign padOut = (altSelQ & altOut) | (~altSelQ & drvValQ);
  assign padOe  = (altSelQ & altOe)  | (~altSelQ & ~dirQ & drvEnQ);

  // read-back
  always_comb begin
    unique case (stb.rdSel)
      SEL_ALT:    rdWord = WORD_W'(altSelQ);
      SEL_DIR:    rdWord = WORD_W'(dirQ);
      SEL_DRVEN:  rdWord = WORD_W'(drvEnQ);
      SEL_DRVVAL: rdWord = WORD_W'(drvValQ);
      SEL_PINS:   rdWord = WORD_W'(syncQ);
      SEL_MASK:   rdWord = WORD_W'(maskQ);
      SEL_STAT:   rdWord = WORD_W'(statusQ);
      SEL_KIND:   rdWord = WORD_W'(kindQ);
      SEL_POL:    rdWord = WORD_W'(polQ);
      SEL_BOTH:   rdWord = WORD_W'(bothQ);
      default:    rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdStb) begin
      busRdata <= rdWord;
    end
  end

endmodule

// File: rtl/gpio_hub.sv
module gpio_hub
  import gpio_hub_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  input  logic                 busRe,
  output logic [31:0]          busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic                 irqOut
);

  hubStrobe_t           stb;
  logic [PIN_COUNT-1:0] statusQ, maskQ, dirQ, altSelQ;

  gpio_hub_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .stb     (stb)
  );

  gpio_hub_dp #(.PIN_COUNT(PIN_COUNT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrBits   (busWdata[PIN_COUNT-1:0]),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .altOut   (altOut),
    .altOe    (altOe),
    .irqOut   (irqOut),
    .statusQ  (statusQ),
    .maskQ    (maskQ),
    .dirQ     (dirQ),
    .altSelQ  (altSelQ)
  );

endmodule

// File: rtl/gpio_hub_chk.sv
module gpio_hub_chk #(
  parameter int unsigned PIN_COUNT = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [31:0]          busWdata,
  input logic                 busRe,
  input logic [31:0]          busRdata,
  input logic [PIN_COUNT-1:0] padOe,
  input logic                 irqOut,
  input logic [PIN_COUNT-1:0] statusQ,
  input logic [PIN_COUNT-1:0] maskQ,
  input logic [PIN_COUNT-1:0] dirQ,
  input logic [PIN_COUNT-1:0] altSelQ
);

  logic unmapRd;
  assign unmapRd = busRe && ((busAddr[1:0] != 2'b00) || (busAddr >= ADDR_W'(48)));

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(8'h18)) |=> ((maskQ & $past(busWdata[PIN_COUNT-1:0])) == '0)); // R6

  AST_MASKSET_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(8'h1C)) |=>
      ((maskQ & $past(busWdata[PIN_COUNT-1:0])) == $past(busWdata[PIN_COUNT-1:0]))); // R6

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut); // R9

  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & ~altSelQ & dirQ) == '0)); // R3

  AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(8'h20)) |=> (busRdata == 32'($past(statusQ)))); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unmapRd |=> (busRdata == 32'd0)); // R11

endmodule

bind gpio_hub gpio_hub_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRe    (busRe),
  .busRdata (busRdata),
  .padOe    (padOe),
  .irqOut   (irqOut),
  .statusQ  (statusQ),
  .maskQ    (maskQ),
  .dirQ     (dirQ),
  .altSelQ  (altSelQ)
);

// File: tb/gpio_hub_tb_top.sv
module gpio_hub_tb_top;

  localparam int unsigned PINS   = 12;
  localparam int unsigned AW     = 6;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [31:0] FULL   = 32'h0000_0FFF;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic            busWe = 1'b0;
  logic [31:0]     busWdata = '0;
  logic            busRe = 1'b0;
  logic [31:0]     busRdata;
  logic [PINS-1:0] padIn = '0;
  logic [PINS-1:0] padOut, padOe;
  logic [PINS-1:0] altOut = '0;
  logic [PINS-1:0] altOe = '0;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_hub #(.PIN_COUNT(PINS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .altOut(altOut), .altOe(altOe), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a[AW-1:0]; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a[AW-1:0]; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h04, v); chk("R1 dir", v, FULL);
    rd(8'h14, v); chk("R1 mask", v, FULL);
    rd(8'h00, v); chk("R1 alt", v, 32'h0);
    rd(8'h0C, v); chk("R1 drvval", v, 32'h0);
    chk("R1 padOe", 32'(padOe), 32'h0);
    chk("R1 irq", 32'(irqOut), 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h08, 32'h0000_0A5A);
    wr(8'h0C, 32'h0000_03C3);
    rd(8'h08, v); chk("R2 drven", v, 32'h0A5A);
    // R12: data is not updated before the sampling edge
    @(negedge clk);
    busAddr = 6'h0C; busRe = 1'b1;
    #1 chk("R12 hold", busRdata, 32'h0A5A);
    @(negedge clk);
    busRe = 1'b0;
    chk("R12 update", busRdata, 32'h03C3);
    waitCyc(2);
    chk("R12 hold after", busRdata, 32'h03C3);
  endtask

  task automatic t_drive();
    wr(8'h04, 32'h0F0);
    wr(8'h08, 32'hFFF);
    chk("R3 oe", 32'(padOe), 32'hF0F);
    chk("R3 out", 32'(padOut), 32'h3C3);
    wr(8'h08, 32'h00F);
    chk("R3 oe2", 32'(padOe), 32'h00F);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    altOut = 12'h555; altOe = 12'h0F0;
    wr(8'h00, 32'h0FF);
    chk("R4 out", 32'(padOut), 32'h355);
    chk("R4 oe", 32'(padOe), 32'h0F0);
    wr(8'h00, 32'h0);
    chk("R4 back", 32'(padOe), 32'h00F);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    padIn = 12'h6A9;
    rd(8'h10, v); chk("R5 early", v, 32'h0);
    rd(8'h10, v); chk("R5 synced", v, 32'h6A9);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h18, 32'h003); rd(8'h14, v); chk("R6 unmask", v, 32'hFFC);
    wr(8'h1C, 32'h001); rd(8'h14, v); chk("R6 mask", v, 32'hFFD);
    wr(8'h14, 32'h0);   rd(8'h14, v); chk("R6 ro", v, 32'hFFD);
    wr(8'h1C, 32'hFFF); rd(8'h14, v); chk("R6 all", v, 32'hFFF);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); padIn = '0;
    wr(8'h24, 32'h003);
    wr(8'h28, 32'h001);
    waitCyc(5);
    rd(8'h20, v);
    waitCyc(2);
    rd(8'h20, v); chk("R7 active low", v, 32'h002);
    chk("R9 masked quiet", 32'(irqOut), 32'h0);
    @(negedge clk); padIn = 12'h001;
    waitCyc(5);
    rd(8'h20, v); chk("R7 active high", v, 32'h003);
    wr(8'h18, 32'h001);
    chk("R9 irq", 32'(irqOut), 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    rd(8'h20, v); chk("R10 value", v, 32'h003);
    chk("R10 cleared", 32'(irqOut), 32'h0);
    @(negedge clk);
    chk("R10 reasserted", 32'(irqOut), 32'h1);
    padIn = '0;
    waitCyc(5);
    rd(8'h20, v);
    rd(8'h20, v); chk("R10 gone", v, 32'h002);
    chk("R10 irq low", 32'(irqOut), 32'h0);
    wr(8'h1C, 32'hFFF);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(8'h24, 32'h000);
    wr(8'h28, 32'h004);
    wr(8'h2C, 32'h010);
    waitCyc(4);
    rd(8'h20, v);
    @(negedge clk); padIn = 12'h01C;
    waitCyc(4);
    rd(8'h20, v); chk("R8 rise", v, 32'h014);
    @(negedge clk); padIn = 12'h000;
    waitCyc(4);
    rd(8'h20, v); chk("R8 fall", v, 32'h018);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R11 upper bits", v, FULL);
    wr(8'h00, 32'h0);
    rd(8'h30, v); chk("R11 0x30", v, 32'h0);
    rd(8'h3C, v); chk("R11 0x3C", v, 32'h0);
    rd(8'h02, v); chk("R11 unaligned", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_drive();
    t_bypass();
    t_input();
    t_mask();
    t_level();
    t_clear();
    t_edge();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule